// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of one eight-pin general-purpose I/O port. A bus master reaches it through a small 32-bit word-addressed bus. Through this bus the master sets each pin's direction and drive style, reads the synchronized pin levels, and writes the output latch. The output latch can be written whole, or changed one bit at a time through write-only set/clear registers. The block drives the pad outputs and their output enables, and it brings the raw pad inputs into its clock domain through a two-flop synchronizer.

The atomic set/clear register lets software raise some pins and lower others in a single write. Software therefore needs no read-modify-write sequence that an interrupt could split. A dedicated clear-only register covers the common case of lowering pins. Word slot 1 is left empty and reads as zero. It exists so that the later registers keep the same offsets as wider sibling ports.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, every pin's configuration nibble is 4'h4, so the whole configuration word reads 0x44444444. The output latch is 0, `pin_out` is 0, `pin_oe` is 0 and `bus_ready` is low.
- R2: The configuration register at word index 0 (byte offset 0x00) is read/write. Pin n is controlled by bits [4n+3:4n]. Within that nibble the low two bits are the mode and the high two bits are the drive style.
- R3: `pin_oe[n]` is high exactly when the mode field of pin n (configuration bits [4n+1:4n]) is non-zero. The drive-style bits do not affect it.
- R4: Word index 1 (offset 0x04) and word indices 6 and 7 (offsets 0x18 and 0x1C) read as zero. Writes to them change no register, pin output or output enable.
- R5: Word index 2 (offset 0x08) returns the synchronized pin inputs in bits [7:0], with zeros above. A pin change settled before clock edge k is returned by a read sampled at edge k+2, but not by one sampled at edge k. Writes to this index are ignored.
- R6: Word index 3 (offset 0x0C) is the output latch. A write loads bits [7:0], and a read returns the latch in bits [7:0] with zeros above. `pin_out` equals the latch.
- R7: A write to word index 4 (offset 0x10) drives pin n high for each 1 in bit n, and drives pin n low for each 1 in bit n+16. Zero bits, bits [15:8] and bits [31:24] leave pins unchanged. This register reads as zero.
- R8: If one write to word index 4 both sets and clears the same pin, the pin ends high.
- R9: A write to word index 5 (offset 0x14) drives pin n low for each 1 in bit n [7:0] and leaves the other pins unchanged. This register reads as zero.
- R10: Each cycle with `bus_en` high is one access, and `bus_ready` is high in the following cycle and only then. For a read, `bus_rdata` holds the addressed value in that cycle. For a write, it holds zero. A written value reaches `pin_out` and `pin_oe` in that same following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completion, one cycle after bus_en |
| pin_in | input | 8 | Raw pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
The checker checks the following on every cycle:
- the one-cycle ready handshake;
- that pin outputs and enables hold still when no write to their register occurs;
- that set bits always land high even when clear bits for the same pin are present;
- that clear-only writes leave every named pin low;
- that the empty slots and write-only registers read as zero;
- that reserved writes disturb nothing.

The exact arithmetic of mixed set/clear words, the per-nibble mode decode, the two-cycle input latency, and the return to defaults after a mid-run reset can only be shown by the bench's scenarios, which compare against values worked out by hand.

// File: rtl/gpio_port_pkg.sv
// Package: gpio_port_pkg
// Shared constants for the GPIO port register block: the word indices of
// each register slot and the bus geometry. Assumes a word-addressed bus.
package gpio_port_pkg;
    localparam int BUS_W   = 32;
    localparam int SEL_W   = 3;
    localparam int HALF_W  = BUS_W / 2;

    localparam logic [SEL_W-1:0] SLOT_CFG    = 3'd0;
    localparam logic [SEL_W-1:0] SLOT_RSVD   = 3'd1;
    localparam logic [SEL_W-1:0] SLOT_IN     = 3'd2;
    localparam logic [SEL_W-1:0] SLOT_OUT    = 3'd3;
    localparam logic [SEL_W-1:0] SLOT_SETCLR = 3'd4;
    localparam logic [SEL_W-1:0] SLOT_CLR    = 3'd5;

    typedef struct packed {
        logic cfg;
        logic out;
        logic setclr;
        logic clr;
    } wr_strobe_t;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchronizer for the asynchronous pad inputs. Each bit is
// synchronized on its own; multi-bit coherence is not guaranteed.
// Assumes a synchronous active-low reset that clears both stages.
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Shift pad levels through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_cfg_reg.sv
// Module: gpio_cfg_reg
// Per-pin configuration register, one nibble per pin (mode in the low two
// bits, drive style in the high two). Derives each pin's output enable
// from a non-zero mode. Assumes 4*NUM_PINS fits the bus word.
module gpio_cfg_reg #(
    parameter int         NUM_PINS  = 8,
    parameter logic [3:0] RST_NIB   = 4'h4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [4*NUM_PINS-1:0] wr_data,
    output logic [4*NUM_PINS-1:0] cfg_q,
    output logic [NUM_PINS-1:0]   oe
);
    localparam int CFG_W = 4 * NUM_PINS;
    localparam logic [CFG_W-1:0] CFG_RST = {NUM_PINS{RST_NIB}};

    // Hold the configuration word; load it whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= CFG_RST;
        else if (wr_en) cfg_q <= wr_data;
    end

    // One enable decoder per pin: any non-zero mode drives the pad.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
        assign oe[p] = |cfg_q[4*p +: 2];
    end
endmodule

// File: rtl/gpio_out_reg.sv
// Module: gpio_out_reg
// Output latch with three write paths: whole load, combined set/clear
// (set wins on conflict) and clear-only. Assumes at most one write path
// is strobed per cycle; the decoder guarantees this.
module gpio_out_reg #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                setclr_en,
    input  logic                clr_en,
    input  logic [NUM_PINS-1:0] load_val,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] rst_mask,
    output logic [NUM_PINS-1:0] latch_q
);
    logic [NUM_PINS-1:0] latch_d;

    // Next latch value from whichever write path is active.
    always_comb begin
        latch_d = latch_q;
        if (load_en)   latch_d = load_val;
        if (clr_en)    latch_d = latch_d & ~set_mask;
        if (setclr_en) latch_d = (latch_d & ~rst_mask) | set_mask;
    end

    // Register the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs (top)
// Register block for one GPIO port on a word-addressed 32-bit bus. Decodes
// word indices, runs the configuration and output registers, synchronizes
// pad inputs and returns read data one cycle after each access together
// with a ready pulse. Assumes NUM_PINS <= 8 so the nibble map fits a word
// and set/clear halves fit 16 bits each.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int         NUM_PINS = 8,
    parameter logic [3:0] RST_NIB  = 4'h4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [SEL_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 bus_ready,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe
);
    localparam int CFG_W = 4 * NUM_PINS;

    wr_strobe_t          wr;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] out_q;
    logic [BUS_W-1:0]    rd_mux;

    // Decode one write strobe per writable slot.
    always_comb begin
        wr        = '0;
        if (bus_en && bus_we) begin
            wr.cfg    = (bus_addr == SLOT_CFG);
            wr.out    = (bus_addr == SLOT_OUT);
            wr.setclr = (bus_addr == SLOT_SETCLR);
            wr.clr    = (bus_addr == SLOT_CLR);
        end
    end

    gpio_cfg_reg #(
        .NUM_PINS (NUM_PINS),
        .RST_NIB  (RST_NIB)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr.cfg),
        .wr_data (bus_wdata[CFG_W-1:0]),
        .cfg_q   (cfg_q),
        .oe      (pin_oe)
    );

    gpio_out_reg #(
        .NUM_PINS (NUM_PINS)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (wr.out),
        .setclr_en (wr.setclr),
        .clr_en    (wr.clr),
        .load_val  (bus_wdata[NUM_PINS-1:0]),
        .set_mask  (bus_wdata[NUM_PINS-1:0]),
        .rst_mask  (bus_wdata[HALF_W +: NUM_PINS]),
        .latch_q   (out_q)
    );

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    assign pin_out = out_q;

    // Select read data; write-only, reserved and unused slots return zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            SLOT_CFG: rd_mux[CFG_W-1:0]    = cfg_q;
            SLOT_IN:  rd_mux[NUM_PINS-1:0] = in_sync;
            SLOT_OUT: rd_mux[NUM_PINS-1:0] = out_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register read data and the ready pulse one cycle after each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_en;
            if (bus_en) bus_rdata <= bus_we ? '0 : rd_mux;
        end
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
// Module: gpio_port_regs_chk
// Cycle-by-cycle properties of the GPIO port block, observed at its ports
// only. Bound to every instance of gpio_port_regs below.
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [SEL_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic                bus_ready,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    logic wr_sc, wr_clr, rd_zero;
    assign wr_sc   = bus_en && bus_we && (bus_addr == 3'd4);
    assign wr_clr  = bus_en && bus_we && (bus_addr == 3'd5);
    assign rd_zero = bus_en && !bus_we && (bus_addr == 3'd1 || bus_addr >= 3'd4);

    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> bus_ready);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !bus_ready);
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> $stable(pin_out));
    p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == 3'd0) |=> $stable(pin_oe));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));
    p_reset_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> ((pin_out & $past(bus_wdata[16 +: NUM_PINS]) & ~$past(bus_wdata[NUM_PINS-1:0])) == '0));
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));
    p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> (bus_rdata == '0));
    p_in_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == 3'd2) |=> (bus_rdata[BUS_W-1:NUM_PINS] == '0));
    p_rsvd_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 3'd1 && (|bus_wdata)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/sim_gpio_port_regs.sv
// Bench for gpio_port_regs: a vector table walked by one loop, then
// directed tests for input synchronization latency and mid-run reset.
module sim_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [7:0]  po;
        logic [7:0]  oe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{1'b0, 3'd0, 32'h0,        32'h44444444, 8'h00, 8'h00, 4'd2},  // R2 default cfg
        '{1'b1, 3'd0, 32'h44414444, 32'h0,        8'h00, 8'h10, 4'd3},  // R3 pin4 mode 1
        '{1'b0, 3'd0, 32'h0,        32'h44414444, 8'h00, 8'h10, 4'd2},  // R2 read back
        '{1'b1, 3'd4, 32'h00000010, 32'h0,        8'h10, 8'h10, 4'd7},  // R7 set pin4
        '{1'b1, 3'd5, 32'h00000010, 32'h0,        8'h00, 8'h10, 4'd9},  // R9 clear pin4
        '{1'b1, 3'd3, 32'h000000A5, 32'h0,        8'hA5, 8'h10, 4'd6},  // R6 load latch
        '{1'b0, 3'd3, 32'h0,        32'h000000A5, 8'hA5, 8'h10, 4'd6},  // R6 read latch
        '{1'b1, 3'd4, 32'h00810042, 32'h0,        8'h66, 8'h10, 4'd7},  // R7 mixed set/clear
        '{1'b1, 3'd4, 32'h00030003, 32'h0,        8'h67, 8'h10, 4'd8},  // R8 set wins
        '{1'b0, 3'd4, 32'h0,        32'h0,        8'h67, 8'h10, 4'd7},  // R7 reads zero
        '{1'b0, 3'd5, 32'h0,        32'h0,        8'h67, 8'h10, 4'd9},  // R9 reads zero
        '{1'b1, 3'd1, 32'hFFFFFFFF, 32'h0,        8'h67, 8'h10, 4'd4},  // R4 reserved write
        '{1'b0, 3'd1, 32'h0,        32'h0,        8'h67, 8'h10, 4'd4},  // R4 reserved read
        '{1'b0, 3'd0, 32'h0,        32'h44414444, 8'h67, 8'h10, 4'd4},  // R4 cfg untouched
        '{1'b1, 3'd0, 32'h33332211, 32'h0,        8'h67, 8'hFF, 4'd3},  // R3 all modes set
        '{1'b1, 3'd0, 32'h4C8C0000, 32'h0,        8'h67, 8'h00, 4'd3},  // R3 style bits only
        '{1'b1, 3'd4, 32'hFF00FF00, 32'h0,        8'h67, 8'h00, 4'd7},  // R7 spare bits ignored
        '{1'b1, 3'd3, 32'hFFFFFF00, 32'h0,        8'h00, 8'h00, 4'd6},  // R6 upper bits dropped
        '{1'b0, 3'd3, 32'h0,        32'h00000000, 8'h00, 8'h00, 4'd6},  // R6 upper read zero
        '{1'b1, 3'd2, 32'h000000FF, 32'h0,        8'h00, 8'h00, 4'd5},  // R5 input write ignored
        '{1'b0, 3'd6, 32'h0,        32'h0,        8'h00, 8'h00, 4'd4}   // R4 unused slot
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus access; returns at the following negedge with results valid.
    task automatic access(input logic we, input logic [2:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 ready", {31'h0, bus_ready}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VT[i].we, VT[i].wa, VT[i].wd);
            n_chk++;
            if (bus_ready !== 1'b1 || bus_rdata !== VT[i].rd ||
                pin_out !== VT[i].po || pin_oe !== VT[i].oe) begin
                n_fail++;
                $display("FAIL R%0d/R10 vec %0d actual rd=%h out=%h oe=%h rdy=%b expected rd=%h out=%h oe=%h rdy=1",
                         VT[i].req, i, bus_rdata, pin_out, pin_oe, bus_ready, VT[i].rd, VT[i].po, VT[i].oe);
            end
        end

        // R10 ready drops when no access follows
        @(negedge clk);
        check("R10 ready idle", {31'h0, bus_ready}, 32'h0);

        // R5 two-flop latency: new level visible at the third back-to-back read
        pin_in = 8'h5A;
        access(1'b0, 3'd2, 32'h0);
        check("R5 read at edge k", bus_rdata, 32'h0);
        access(1'b0, 3'd2, 32'h0);
        access(1'b0, 3'd2, 32'h0);
        check("R5 read at edge k+2", bus_rdata, 32'h0000005A);
        pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        access(1'b0, 3'd2, 32'h0);
        check("R5 settled read", bus_rdata, 32'h000000C3);

        // R1 mid-run reset restores defaults
        access(1'b1, 3'd3, 32'h000000FF);
        access(1'b1, 3'd0, 32'h11111111);
        check("R6 pre-reset out", {24'h0, pin_out}, 32'hFF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 out after reset", {24'h0, pin_out}, 32'h0);
        check("R1 oe after reset", {24'h0, pin_oe}, 32'h0);
        access(1'b0, 3'd0, 32'h0);
        check("R1 cfg after reset", bus_rdata, 32'h44444444);
        access(1'b0, 3'd3, 32'h0);
        check("R1 latch after reset", bus_rdata, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule